// File: doc/BRIEF.md
# Dual-Clock Interprocessor Mailbox

This block connects two processors that run on unrelated clocks and lets them pass 32-bit words and ring each other's doorbells. Each processor sees its own register set through a simple port of write strobe, read strobe, word address, write data, read data and a ready flag. The two register sets have the same layout, so software on either processor uses the same driver.

Each direction has four data channels and four doorbells. Writing a transmit register hands the word to the far side. The word is carried across the clock boundary by a toggle request, and the sender keeps it stable until the far side reads it. The far side's read sends a toggle acknowledge back, which marks the local transmit slot as empty again. A doorbell carries no data. Ringing one toggles a line that sets a pending flag on the far side, and that flag stays set until software clears it. Each side has one level-high interrupt. It is the OR of every pending source whose enable bit is set.

Top module: `xmb_mailbox`

## Requirements
- R1: After reset, ready goes high and stays high. The status register reads 0x0000000F, meaning all four transmit slots are empty and every other flag is clear. Both interrupts are low.
- R2: A write to word address c (0..3) on one side puts that word into the far side's receive register at address 4+c. It also sets the far side's receive-full bit at status bit 4+c. Each channel carries its own word independently.
- R3: A write to transmit address c while status bit c (transmit empty) is 0 is dropped and leaves the held word unchanged. It sets the sticky overrun bit at status bit 12+c. The far side still receives the original word.
- R4: Reading receive address 4+c while it is full returns the word and clears status bit 4+c. Afterwards the sender's transmit-empty bit c returns to 1.
- R5: Writing a 1 to bit d of the ring register (address 10) sets doorbell-pending bit 8+d in the far side's status. It changes no transmit-empty bit on either side.
- R6: Writing 1 to status bits 8..15 (address 8) clears the matching doorbell-pending or overrun bit. Writing 0 to those bits leaves them unchanged.
- R7: The enable register (address 9) holds three fields: bits 3..0 enable transmit-empty, bits 7..4 enable receive-full, and bits 11..8 enable doorbell-pending. The interrupt output is high exactly when an enabled source is set. Overrun is not an interrupt source.
- R8: Both directions behave alike. Words written on side B arrive at side A on the same channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A bus clock |
| rst_a_n | input | 1 | Side A asynchronous active-low reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | AW | Side A word address |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, valid in the cycle of the read strobe |
| a_ready | output | 1 | Side A accepts accesses |
| a_irq | output | 1 | Side A interrupt, level high |
| clk_b | input | 1 | Side B bus clock |
| rst_b_n | input | 1 | Side B asynchronous active-low reset |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | AW | Side B word address |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, valid in the cycle of the read strobe |
| b_ready | output | 1 | Side B accepts accesses |
| b_irq | output | 1 | Side B interrupt, level high |

## Verification
A lost or duplicated toggle shows at the ports as a receive-full bit that never sets or a transmit-empty bit that never returns. A stale word shows as the wrong value read back at the far side. These appear within a few far-side clocks of the synchronizer delay. A flag that is wrong but not enabled stays hidden at the interrupt pin. It is still visible in the status word on the next read, so the bench reads status after every stimulus and also checks the interrupt one registered cycle after each enable change.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  typedef enum logic [2:0] {
    RK_TX,
    RK_RX,
    RK_STAT,
    RK_IEN,
    RK_RING,
    RK_NONE
  } reg_kind_e;

  // Word map: transmit slots, then receive slots, then status, enable, ring.
  function automatic reg_kind_e kind_of(input int a, input int nch);
    if (a < nch)               return RK_TX;
    else if (a < 2 * nch)      return RK_RX;
    else if (a == 2 * nch)     return RK_STAT;
    else if (a == 2 * nch + 1) return RK_IEN;
    else if (a == 2 * nch + 2) return RK_RING;
    else                       return RK_NONE;
  endfunction

  function automatic int chan_of(input int a, input int nch);
    if (a < nch) return a;
    else         return a - nch;
  endfunction

endpackage

// File: rtl/xmb_rstsync.sv
module xmb_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
    end else begin
      st_q[0] <= d;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/xmb_side.sv
module xmb_side
  import xmb_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              ready,
  output logic              irq,
  output logic [NCH*DW-1:0] tx_data,
  output logic [NCH-1:0]    tx_req,
  output logic [NCH-1:0]    rx_ack,
  output logic [NCH-1:0]    db_ring,
  input  logic [NCH*DW-1:0] far_data,
  input  logic [NCH-1:0]    far_req,
  input  logic [NCH-1:0]    far_ack,
  input  logic [NCH-1:0]    far_db
);
  localparam int SRC_W  = 3 * NCH;
  localparam int STAT_W = 4 * NCH;
  localparam int OFS_DB  = 2 * NCH;
  localparam int OFS_OVR = 3 * NCH;

  logic rst_s_n;
  logic ready_q, ready_d;
  logic acc_wr, acc_rd;
  reg_kind_e kind;
  int chan;

  logic [NCH-1:0] s_req, s_ack, s_db;
  logic [NCH-1:0] busy_v, full_v, pend_v, ovr_v;
  logic [DW-1:0]  txd_v [NCH];
  logic [DW-1:0]  rxd_v [NCH];

  logic [SRC_W-1:0]  ien_q, ien_d;
  logic              irq_q, irq_d;
  logic [STAT_W-1:0] stat_w;

  xmb_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  xmb_sync #(.W(3 * NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     ({far_db, far_ack, far_req}),
    .q     ({s_db, s_ack, s_req})
  );

  // Access qualification and decode
  always_comb begin
    ready_d = 1'b1;
    acc_wr  = wr & ready_q;
    acc_rd  = rd & ready_q;
    kind    = kind_of(int'(addr), NCH);
    chan    = chan_of(int'(addr), NCH);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ready_q <= 1'b0;
    else          ready_q <= ready_d;
  end

  // Per-channel state: transmit slot, receive slot, doorbell
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          busy_q, busy_d;
    logic [DW-1:0] txd_q, txd_d;
    logic          treq_q, treq_d;
    logic          ovr_q, ovr_d;
    logic [DW-1:0] rxd_q, rxd_d;
    logic          full_q, full_d;
    logic          ack_q, ack_d;
    logic          pend_q, pend_d;
    logic          dbt_q, dbt_d;
    logic          req_seen_q, ack_seen_q, db_seen_q;
    logic          hit_tx, hit_rx, hit_stat, hit_ring;
    logic          evt_req, evt_ack, evt_db;

    always_comb begin
      hit_tx   = acc_wr && (kind == RK_TX) && (chan == i);
      hit_rx   = acc_rd && (kind == RK_RX) && (chan == i);
      hit_stat = acc_wr && (kind == RK_STAT);
      hit_ring = acc_wr && (kind == RK_RING) && wdata[i];
      evt_req  = s_req[i] ^ req_seen_q;
      evt_ack  = s_ack[i] ^ ack_seen_q;
      evt_db   = s_db[i]  ^ db_seen_q;

      busy_d = busy_q;
      txd_d  = txd_q;
      treq_d = treq_q;
      ovr_d  = ovr_q;
      rxd_d  = rxd_q;
      full_d = full_q;
      ack_d  = ack_q;
      pend_d = pend_q;
      dbt_d  = dbt_q;

      if (hit_tx) begin
        if (busy_q) begin
          ovr_d = 1'b1;
        end else begin
          txd_d  = wdata;
          busy_d = 1'b1;
          treq_d = ~treq_q;
        end
      end
      if (evt_ack) busy_d = 1'b0;
      if (hit_stat && wdata[OFS_OVR + i]) ovr_d = 1'b0;

      if (hit_rx && full_q) begin
        full_d = 1'b0;
        ack_d  = ~ack_q;
      end
      if (evt_req) begin
        rxd_d  = far_data[i*DW +: DW];
        full_d = 1'b1;
      end

      if (hit_stat && wdata[OFS_DB + i]) pend_d = 1'b0;
      if (evt_db) pend_d = 1'b1;

      if (hit_ring) dbt_d = ~dbt_q;
    end

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) begin
        busy_q     <= 1'b0;
        txd_q      <= '0;
        treq_q     <= 1'b0;
        ovr_q      <= 1'b0;
        rxd_q      <= '0;
        full_q     <= 1'b0;
        ack_q      <= 1'b0;
        pend_q     <= 1'b0;
        dbt_q      <= 1'b0;
        req_seen_q <= 1'b0;
        ack_seen_q <= 1'b0;
        db_seen_q  <= 1'b0;
      end else begin
        busy_q     <= busy_d;
        txd_q      <= txd_d;
        treq_q     <= treq_d;
        ovr_q      <= ovr_d;
        rxd_q      <= rxd_d;
        full_q     <= full_d;
        ack_q      <= ack_d;
        pend_q     <= pend_d;
        dbt_q      <= dbt_d;
        req_seen_q <= s_req[i];
        ack_seen_q <= s_ack[i];
        db_seen_q  <= s_db[i];
      end
    end

    assign tx_data[i*DW +: DW] = txd_q;
    assign tx_req[i]  = treq_q;
    assign rx_ack[i]  = ack_q;
    assign db_ring[i] = dbt_q;
    assign busy_v[i]  = busy_q;
    assign full_v[i]  = full_q;
    assign pend_v[i]  = pend_q;
    assign ovr_v[i]   = ovr_q;
    assign txd_v[i]   = txd_q;
    assign rxd_v[i]   = rxd_q;
  end

  // Enable register and combined interrupt
  always_comb begin
    ien_d = ien_q;
    if (acc_wr && (kind == RK_IEN)) ien_d = wdata[SRC_W-1:0];
    irq_d = |({pend_v, full_v, ~busy_v} & ien_q);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ien_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq_q <= irq_d;
    end
  end

  // Read data, valid in the strobe cycle
  always_comb begin
    stat_w = {ovr_v, pend_v, full_v, ~busy_v};
    rdata  = '0;
    case (kind)
      RK_TX:   rdata = txd_v[chan];
      RK_RX:   rdata = rxd_v[chan];
      RK_STAT: rdata[STAT_W-1:0] = stat_w;
      RK_IEN:  rdata[SRC_W-1:0]  = ien_q;
      default: rdata = '0;
    endcase
  end

  assign ready = ready_q;
  assign irq   = irq_q;
endmodule

// File: rtl/xmb_mailbox.sv
module xmb_mailbox #(
  parameter int NCH         = 4,
  parameter int DW          = 32,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_a,
  input  logic          rst_a_n,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_ready,
  output logic          a_irq,
  input  logic          clk_b,
  input  logic          rst_b_n,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_ready,
  output logic          b_irq
);
  logic [NCH*DW-1:0] a_txd, b_txd;
  logic [NCH-1:0]    a_req, b_req;
  logic [NCH-1:0]    a_ack, b_ack;
  logic [NCH-1:0]    a_db,  b_db;

  xmb_side #(.NCH(NCH), .DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_sa (
    .clk      (clk_a),
    .rst_n    (rst_a_n),
    .wr       (a_wr),
    .rd       (a_rd),
    .addr     (a_addr),
    .wdata    (a_wdata),
    .rdata    (a_rdata),
    .ready    (a_ready),
    .irq      (a_irq),
    .tx_data  (a_txd),
    .tx_req   (a_req),
    .rx_ack   (a_ack),
    .db_ring  (a_db),
    .far_data (b_txd),
    .far_req  (b_req),
    .far_ack  (b_ack),
    .far_db   (b_db)
  );

  xmb_side #(.NCH(NCH), .DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_sb (
    .clk      (clk_b),
    .rst_n    (rst_b_n),
    .wr       (b_wr),
    .rd       (b_rd),
    .addr     (b_addr),
    .wdata    (b_wdata),
    .rdata    (b_rdata),
    .ready    (b_ready),
    .irq      (b_irq),
    .tx_data  (b_txd),
    .tx_req   (b_req),
    .rx_ack   (b_ack),
    .db_ring  (b_db),
    .far_data (a_txd),
    .far_req  (a_req),
    .far_ack  (a_ack),
    .far_db   (a_db)
  );
endmodule

// File: rtl/xmb_chk.sv
module xmb_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input logic              clk_a,
  input logic              rst_a_n,
  input logic              a_wr,
  input logic              a_rd,
  input logic              a_ready,
  input logic              a_irq,
  input logic [NCH*DW-1:0] a_txd,
  input logic [NCH-1:0]    a_req,
  input logic [NCH-1:0]    a_ack,
  input logic [NCH-1:0]    a_db,
  input logic              clk_b,
  input logic              rst_b_n,
  input logic              b_wr,
  input logic              b_rd,
  input logic              b_ready,
  input logic [NCH*DW-1:0] b_txd,
  input logic [NCH-1:0]    b_req,
  input logic [NCH-1:0]    b_ack
);
  // R1: ready never drops while out of reset
  p_ready_holds_r1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $past(a_ready) |-> a_ready);

  // R2: a transfer request only follows an accepted write
  p_req_after_write_r2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_req != $past(a_req)) |-> $past(a_wr && a_ready));

  // R3: the held word only changes together with a new request
  p_word_held_r3: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_txd != $past(a_txd)) |-> (a_req != $past(a_req)));

  // R4: an acknowledge toggle only follows an accepted read
  p_ack_after_read_r4: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_ack != $past(b_ack)) |-> $past(b_rd && b_ready));

  // R5: a doorbell toggle only follows an accepted write
  p_ring_after_write_r5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_db != $past(a_db)) |-> $past(a_wr && a_ready));

  // R7: no interrupt before the side accepts accesses
  p_irq_needs_ready_r7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    a_irq |-> a_ready);

  // R8: mirrored direction keeps its word held as well
  p_word_held_b_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_txd != $past(b_txd)) |-> (b_req != $past(b_req)));

  p_ack_after_read_a_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (a_ack != $past(a_ack)) |-> $past(a_rd && a_ready));

  p_req_after_write_b_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_req != $past(b_req)) |-> $past(b_wr && b_ready));
endmodule

bind xmb_mailbox xmb_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_a   (clk_a),
  .rst_a_n (rst_a_n),
  .a_wr    (a_wr),
  .a_rd    (a_rd),
  .a_ready (a_ready),
  .a_irq   (a_irq),
  .a_txd   (a_txd),
  .a_req   (a_req),
  .a_ack   (a_ack),
  .a_db    (a_db),
  .clk_b   (clk_b),
  .rst_b_n (rst_b_n),
  .b_wr    (b_wr),
  .b_rd    (b_rd),
  .b_ready (b_ready),
  .b_txd   (b_txd),
  .b_req   (b_req),
  .b_ack   (b_ack)
);

// File: tb/sim_xmb_mailbox.sv
`timescale 1ns/1ps
module sim_xmb_mailbox;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [3:0] A_STAT = 4'd8;
  localparam logic [3:0] A_IEN  = 4'd9;
  localparam logic [3:0] A_RING = 4'd10;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n, rst_b_n;
  logic a_wr, a_rd, b_wr, b_rd;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_ready, b_ready, a_irq, b_irq;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    bit          dst;
    int          ch;
    logic [31:0] w;
  } exp_t;
  exp_t exp_q [$];

  always #10 clk_a = ~clk_a;
  always #7  clk_b = ~clk_b;

  xmb_mailbox u0 (
    .clk_a (clk_a), .rst_a_n (rst_a_n), .a_wr (a_wr), .a_rd (a_rd),
    .a_addr (a_addr), .a_wdata (a_wdata), .a_rdata (a_rdata),
    .a_ready (a_ready), .a_irq (a_irq),
    .clk_b (clk_b), .rst_b_n (rst_b_n), .b_wr (b_wr), .b_rd (b_rd),
    .b_addr (b_addr), .b_wdata (b_wdata), .b_rdata (b_rdata),
    .b_ready (b_ready), .b_irq (b_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit sd, input bit w, input logic [3:0] ad,
                     input logic [31:0] wd, output logic [31:0] rdv);
    if (!sd) begin
      @(negedge clk_a);
      a_wr = w; a_rd = !w; a_addr = ad; a_wdata = wd;
      #1 rdv = a_rdata;
      @(posedge clk_a);
      #1 a_wr = 1'b0; a_rd = 1'b0;
    end else begin
      @(negedge clk_b);
      b_wr = w; b_rd = !w; b_addr = ad; b_wdata = wd;
      #1 rdv = b_rdata;
      @(posedge clk_b);
      #1 b_wr = 1'b0; b_rd = 1'b0;
    end
  endtask

  task automatic wr(input bit sd, input logic [3:0] ad, input logic [31:0] wd);
    logic [31:0] dummy;
    acc(sd, 1'b1, ad, wd, dummy);
  endtask

  task automatic rd(input bit sd, input logic [3:0] ad, output logic [31:0] v);
    acc(sd, 1'b0, ad, 32'h0, v);
  endtask

  task automatic wait_bit(input bit sd, input int bn, input bit val);
    logic [31:0] s;
    for (int k = 0; k < 100; k++) begin
      rd(sd, A_STAT, s);
      if (s[bn] == val) break;
    end
  endtask

  task automatic settle(input bit sd);
    if (!sd) repeat (3) @(posedge clk_a);
    else     repeat (3) @(posedge clk_b);
    #1;
  endtask

  // Driver: write a transmit slot and record what the far side must see
  task automatic send(input bit sd, input int ch, input logic [31:0] w);
    exp_t e;
    wr(sd, 4'(ch), w);
    e.dst = !sd; e.ch = ch; e.w = w;
    exp_q.push_back(e);
  endtask

  // Monitor: pop each expected word and compare against the far receive slot
  task automatic drain(input string tag);
    exp_t e;
    logic [31:0] v, s;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      wait_bit(e.dst, 4 + e.ch, 1'b1);
      rd(e.dst, 4'(4 + e.ch), v);
      chk({tag, " word"}, v, e.w);
      rd(e.dst, A_STAT, s);
      chk("R4 full cleared by read", 32'(s[4 + e.ch]), 32'd0);
    end
  endtask

  initial begin
    #(100000 * 20);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_a_n = 1'b0; rst_b_n = 1'b0;
    a_wr = 0; a_rd = 0; a_addr = '0; a_wdata = '0;
    b_wr = 0; b_rd = 0; b_addr = '0; b_wdata = '0;
    repeat (4) @(posedge clk_a);
    #1 rst_a_n = 1'b1; rst_b_n = 1'b1;
    repeat (5) @(posedge clk_a);
    #1;

    // R1 reset state
    chk("R1 a_ready", 32'(a_ready), 32'd1);
    chk("R1 b_ready", 32'(b_ready), 32'd1);
    chk("R1 a_irq", 32'(a_irq), 32'd0);
    chk("R1 b_irq", 32'(b_irq), 32'd0);
    rd(0, A_STAT, v); chk("R1 a status", v, 32'h0000000F);
    rd(1, A_STAT, v); chk("R1 b status", v, 32'h0000000F);

    // R2 four independent words A to B
    send(0, 0, 32'hA0A0_0001);
    send(0, 1, 32'h1234_5678);
    send(0, 2, 32'hFFFF_0000);
    send(0, 3, 32'h0000_FFFF);
    wait_bit(1, 7, 1'b1);
    rd(1, A_STAT, v); chk("R2 b full bits", 32'(v[7:4]), 32'hF);
    rd(0, A_STAT, v); chk("R2 a tx not empty", 32'(v[3:0]), 32'h0);
    drain("R2");
    wait_bit(0, 3, 1'b1);
    rd(0, A_STAT, v); chk("R4 a tx empty again", 32'(v[3:0]), 32'hF);

    // R8 mirror direction
    send(1, 2, 32'hBEEF_0002);
    send(1, 3, 32'hCAFE_0003);
    drain("R8");
    wait_bit(1, 3, 1'b1);
    rd(1, A_STAT, v); chk("R8 b tx empty again", 32'(v[3:0]), 32'hF);

    // R3 overrun
    send(0, 0, 32'h1111_1111);
    wr(0, 4'd0, 32'h2222_2222);
    rd(0, A_STAT, v); chk("R3 overrun bit", 32'(v[12]), 32'd1);
    rd(0, 4'd0, v);   chk("R3 held word", v, 32'h1111_1111);
    settle(0);
    chk("R7 overrun not a source", 32'(a_irq), 32'd0);
    drain("R3");
    wait_bit(0, 0, 1'b1);
    rd(0, A_STAT, v); chk("R4 a empty after overrun", 32'(v[0]), 32'd1);

    // R6 clear of overrun
    wr(0, A_STAT, 32'h0);
    rd(0, A_STAT, v); chk("R6 zero write keeps", 32'(v[12]), 32'd1);
    wr(0, A_STAT, 32'h0000_1000);
    rd(0, A_STAT, v); chk("R6 overrun cleared", 32'(v[12]), 32'd0);

    // R5 doorbells
    wr(0, A_RING, 32'h5);
    wait_bit(1, 10, 1'b1);
    rd(1, A_STAT, v); chk("R5 b pending", 32'(v[11:8]), 32'h5);
    chk("R5 b tx unchanged", 32'(v[3:0]), 32'hF);
    rd(0, A_STAT, v); chk("R5 a no ack", v, 32'h0000000F);
    wr(1, A_STAT, 32'h0000_0100);
    rd(1, A_STAT, v); chk("R6 pending cleared", 32'(v[11:8]), 32'h4);

    // R7 interrupt combining
    wr(0, A_IEN, 32'h1);
    settle(0); chk("R7 tx-empty irq", 32'(a_irq), 32'd1);
    rd(0, A_IEN, v); chk("R7 enable readback", v, 32'h1);
    wr(0, A_IEN, 32'h0);
    settle(0); chk("R7 irq off", 32'(a_irq), 32'd0);
    wr(1, A_IEN, 32'h10);
    settle(1); chk("R7 rx irq idle", 32'(b_irq), 32'd0);
    send(0, 0, 32'h5A5A_5A5A);
    wait_bit(1, 4, 1'b1);
    settle(1); chk("R7 rx-full irq", 32'(b_irq), 32'd1);
    drain("R7");
    settle(1); chk("R7 rx irq cleared", 32'(b_irq), 32'd0);
    wr(1, A_IEN, 32'h400);
    settle(1); chk("R7 doorbell irq", 32'(b_irq), 32'd1);
    wr(1, A_STAT, 32'h0000_0400);
    settle(1); chk("R7 doorbell irq cleared", 32'(b_irq), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule